// File: doc/BRIEF.md
# Load/Store Port Memory Responder

This block sits on the memory side of a processor load/store port and answers requests from a small byte-addressable array inside it. A requester waits until `busy_o` is low. It then raises a load or a store select together with an address-valid strobe, an access length and three mode bits. The block acknowledges the address with a one-cycle `addr_ok_o`. For a store, the requester then gives the data on a one-cycle `st_vld_i` strobe. For a load, the block returns zero-extended data with a one-cycle `ld_vld_o`. Instead of the acknowledge, the block may raise an exception flag with a cause code. The exception ends the transaction and the array is left untouched.

Bytes are placed little-endian within a word of `LANES` bytes. An access may not cross a word boundary. A store marked as block-zeroing clears the whole word that holds its address. The mode bits are captured when a request is accepted and are shown on `mode_o`; they have no other effect.

After a transaction ends, a request that is still held is not taken a second time. The address-valid strobe must go low for at least one cycle before the next request is accepted.

Top module: `lsp_mem_resp`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `busy_o`, `addr_ok_o`, `ld_vld_o` and `exc_o` are all low.
- R2: A request is accepted on a clock edge when the block is idle, the block is armed, `addr_vld_i` is high and at least one select is high. `busy_o` is high from the cycle after acceptance until the transaction ends. At most one of `addr_ok_o`, `ld_vld_o` and `exc_o` is high in any cycle.
- R3: For a legal request, `addr_ok_o` is high for exactly one cycle, and that cycle is the one directly after acceptance.
- R4: A store writes `st_data_i` on the first edge, at or after the `addr_ok_o` cycle, at which `st_vld_i` is high. Until that edge, `busy_o` stays high and `addr_ok_o` is not repeated. `busy_o` is low in the cycle after the strobe edge. A strobe given while the block is idle writes nothing.
- R5: For a load, `ld_vld_o` is high for exactly one cycle, and that cycle is the one directly after `addr_ok_o`. `ld_data_o` holds the selected bytes zero-extended to the full width. `busy_o` is low in the cycle after `ld_vld_o`.
- R6: Byte k of the store data (bits 8k+7:8k) goes to byte address addr+k. A load returns byte address addr+k in bits 8k+7:8k. Only the low `len_i` bytes of `st_data_i` are written.
- R7: A length other than 1, 2, 4 or 8 raises `exc_o` with cause 2. An access where (address mod LANES) + length > LANES raises `exc_o` with cause 1. When the length is bad, cause 2 wins. `exc_o` comes in the cycle after acceptance, lasts one cycle and comes without `addr_ok_o`. The array is not changed, and `busy_o` is low in the cycle after `exc_o`.
- R8: If both selects are high at acceptance, `exc_o` is raised with cause 3. This takes priority over every other cause.
- R9: After a transaction ends, the block ignores a request that is still held. A new request is accepted only after `addr_vld_i` has been sampled low on at least one edge.
- R10: A store with `zero_blk_i` high writes zero to all LANES bytes of the aligned word that holds the address. It ignores the data. It skips the length check and the boundary check.
- R11: `mode_o` = {privileged, virtual, 32-bit}, sampled from `priv_i`, `virt_i` and `m32_i` at acceptance. It holds that value until the next acceptance.
- R12: The byte address wraps modulo WORDS*LANES. Higher address bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_req_i | input | 1 | Load select |
| st_req_i | input | 1 | Store select |
| zero_blk_i | input | 1 | Marks a store as block-zeroing |
| addr_vld_i | input | 1 | Address-valid strobe |
| addr_i | input | ADDR_W | Byte address |
| len_i | input | 4 | Access length in bytes (1, 2, 4, 8) |
| priv_i | input | 1 | Privileged-mode bit |
| virt_i | input | 1 | Virtual-addressing-mode bit |
| m32_i | input | 1 | 32-bit-mode bit |
| st_vld_i | input | 1 | One-cycle store-data strobe |
| st_data_i | input | 8*LANES | Store data, low bytes used |
| busy_o | output | 1 | Transaction in progress |
| addr_ok_o | output | 1 | Address accepted |
| ld_vld_o | output | 1 | Load data valid |
| ld_data_o | output | 8*LANES | Load data, zero-extended |
| exc_o | output | 1 | Exception flag |
| exc_cause_o | output | 2 | Exception cause (1 boundary, 2 length, 3 both selects) |
| mode_o | output | 3 | Captured mode bits |

## Verification
The main function is tried in three ways:
- Pairs of half-word stores read back by a single wider load. These tell correct little-endian lane placement apart from swapped or shifted lanes.
- Full-word and partial-word stores over the same word, read back by loads of several lengths and offsets. These show whether byte enables confine a write to its own bytes and whether load results are zero-extended.
- Requests that cross the boundary, have a bad length, or raise both selects, each followed by a read-back. These separate cause priority from mere rejection and confirm the array is untouched.

The store-strobe delay varies from zero to two cycles. This separates capture on the strobe edge from capture at a fixed time. A request held after completion checks that the block does not take it twice.

// File: rtl/lsp_pkg.sv
`timescale 1ns/1ps
package lsp_pkg;
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_ACK  = 3'd1,
      ST_STW  = 3'd2,
      ST_LD   = 3'd3,
      ST_EXC  = 3'd4
   } lsp_state_e;

   typedef enum logic [1:0] {
      CAUSE_NONE  = 2'd0,
      CAUSE_CROSS = 2'd1,
      CAUSE_LEN   = 2'd2,
      CAUSE_SEL   = 2'd3
   } lsp_cause_e;

   typedef struct packed {
      logic priv;
      logic virt;
      logic m32;
   } lsp_mode_t;
endpackage

// File: rtl/lsp_req_check.sv
`timescale 1ns/1ps
module lsp_req_check
   import lsp_pkg::*;
#(
   parameter int LANES = 8,
   localparam int OFFW = $clog2(LANES),
   localparam int SUMW = OFFW + 5
) (
   input  logic            ld_sel,
   input  logic            st_sel,
   input  logic            zero_blk,
   input  logic [OFFW-1:0] off,
   input  logic [3:0]      len,
   output lsp_cause_e      cause
);
   logic            len_ok;
   logic [SUMW-1:0] span_end;
   logic            crosses;

   always_comb begin
      len_ok   = (len == 4'd1) || (len == 4'd2) || (len == 4'd4) || (len == 4'd8);
      span_end = SUMW'(off) + SUMW'(len);
      crosses  = span_end > SUMW'(LANES);
      if (ld_sel && st_sel)
         cause = CAUSE_SEL;
      else if (st_sel && zero_blk)
         cause = CAUSE_NONE;
      else if (!len_ok)
         cause = CAUSE_LEN;
      else if (crosses)
         cause = CAUSE_CROSS;
      else
         cause = CAUSE_NONE;
   end
endmodule

// File: rtl/lsp_lane_map.sv
`timescale 1ns/1ps
module lsp_lane_map #(
   parameter int LANES = 8,
   localparam int OFFW = $clog2(LANES),
   localparam int DW   = 8 * LANES
) (
   input  logic [OFFW-1:0] off,
   input  logic [3:0]      len,
   input  logic            zero_blk,
   input  logic [DW-1:0]   wdata_in,
   input  logic [DW-1:0]   rword,
   output logic [LANES-1:0] be,
   output logic [DW-1:0]   wlanes,
   output logic [DW-1:0]   rdata
);
   logic [DW-1:0] rshift;

   assign wlanes = zero_blk ? '0 : (wdata_in << {off, 3'b000});
   assign rshift = rword >> {off, 3'b000};

   for (genvar j = 0; j < LANES; j++) begin : g_lane
      assign be[j] = zero_blk ||
                     ((j >= int'(off)) && (j < int'(off) + int'(len)));
      assign rdata[8*j +: 8] = (j < int'(len)) ? rshift[8*j +: 8] : 8'h00;
   end
endmodule

// File: rtl/lsp_byte_array.sv
`timescale 1ns/1ps
module lsp_byte_array #(
   parameter int LANES = 8,
   parameter int WORDS = 16,
   localparam int IW   = $clog2(WORDS),
   localparam int DW   = 8 * LANES
) (
   input  logic             clk,
   input  logic             we,
   input  logic [LANES-1:0] be,
   input  logic [IW-1:0]    idx,
   input  logic [DW-1:0]    wlanes,
   output logic [DW-1:0]    rword
);
   for (genvar j = 0; j < LANES; j++) begin : g_col
      logic [7:0] cells [WORDS];
      always_ff @(posedge clk) begin
         if (we && be[j])
            cells[idx] <= wlanes[8*j +: 8];
      end
      assign rword[8*j +: 8] = cells[idx];
   end
endmodule

// File: rtl/lsp_mem_resp.sv
`timescale 1ns/1ps
module lsp_mem_resp
   import lsp_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int LANES  = 8,
   parameter int WORDS  = 16,
   localparam int OFFW  = $clog2(LANES),
   localparam int IW    = $clog2(WORDS),
   localparam int DW    = 8 * LANES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_req_i,
   input  logic              st_req_i,
   input  logic              zero_blk_i,
   input  logic              addr_vld_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [3:0]        len_i,
   input  logic              priv_i,
   input  logic              virt_i,
   input  logic              m32_i,
   input  logic              st_vld_i,
   input  logic [DW-1:0]     st_data_i,
   output logic              busy_o,
   output logic              addr_ok_o,
   output logic              ld_vld_o,
   output logic [DW-1:0]     ld_data_o,
   output logic              exc_o,
   output logic [1:0]        exc_cause_o,
   output logic [2:0]        mode_o
);
   if (LANES < 8 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
      $error("LANES must be a power of two of at least 8");
   end
   if (WORDS < 2 || (WORDS & (WORDS - 1)) != 0) begin : g_bad_words
      $error("WORDS must be a power of two of at least 2");
   end
   if (ADDR_W < OFFW + IW) begin : g_bad_addr
      $error("ADDR_W too narrow for the array");
   end
   if (ADDR_W > OFFW + IW) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^addr_i[ADDR_W-1:OFFW+IW];
   end

   lsp_state_e      state_q;
   lsp_cause_e      cause_q, chk_cause;
   lsp_mode_t       mode_q;
   logic            armed_q, is_st_q, zero_q;
   logic [OFFW-1:0] off_q;
   logic [IW-1:0]   idx_q;
   logic [3:0]      len_q;
   logic [DW-1:0]   rdata_q;

   logic             accept, we;
   logic [LANES-1:0] be;
   logic [DW-1:0]    wlanes, rword, lm_rdata;

   lsp_req_check #(.LANES(LANES)) u_check (
      .ld_sel  (ld_req_i),
      .st_sel  (st_req_i),
      .zero_blk(zero_blk_i),
      .off     (addr_i[OFFW-1:0]),
      .len     (len_i),
      .cause   (chk_cause)
   );

   lsp_lane_map #(.LANES(LANES)) u_lanes (
      .off     (off_q),
      .len     (len_q),
      .zero_blk(zero_q),
      .wdata_in(st_data_i),
      .rword   (rword),
      .be      (be),
      .wlanes  (wlanes),
      .rdata   (lm_rdata)
   );

   lsp_byte_array #(.LANES(LANES), .WORDS(WORDS)) u_array (
      .clk   (clk),
      .we    (we),
      .be    (be),
      .idx   (idx_q),
      .wlanes(wlanes),
      .rword (rword)
   );

   assign accept = (state_q == ST_IDLE) && armed_q && addr_vld_i &&
                   (ld_req_i || st_req_i);
   assign we     = is_st_q && st_vld_i &&
                   ((state_q == ST_ACK) || (state_q == ST_STW));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cause_q <= CAUSE_NONE;
         mode_q  <= '0;
         armed_q <= 1'b1;
         is_st_q <= 1'b0;
         zero_q  <= 1'b0;
         off_q   <= '0;
         idx_q   <= '0;
         len_q   <= '0;
         rdata_q <= '0;
      end else begin
         if (!addr_vld_i)
            armed_q <= 1'b1;
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  armed_q <= 1'b0;
                  is_st_q <= st_req_i;
                  zero_q  <= st_req_i && zero_blk_i;
                  off_q   <= addr_i[OFFW-1:0];
                  idx_q   <= addr_i[OFFW +: IW];
                  len_q   <= len_i;
                  mode_q  <= '{priv: priv_i, virt: virt_i, m32: m32_i};
                  cause_q <= chk_cause;
                  state_q <= (chk_cause != CAUSE_NONE) ? ST_EXC : ST_ACK;
               end
            end
            ST_ACK: begin
               if (is_st_q)
                  state_q <= st_vld_i ? ST_IDLE : ST_STW;
               else begin
                  rdata_q <= lm_rdata;
                  state_q <= ST_LD;
               end
            end
            ST_STW:  if (st_vld_i) state_q <= ST_IDLE;
            ST_LD:   state_q <= ST_IDLE;
            ST_EXC:  state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o      = (state_q != ST_IDLE);
   assign addr_ok_o   = (state_q == ST_ACK);
   assign ld_vld_o    = (state_q == ST_LD);
   assign ld_data_o   = ld_vld_o ? rdata_q : '0;
   assign exc_o       = (state_q == ST_EXC);
   assign exc_cause_o = exc_o ? cause_q : CAUSE_NONE;
   assign mode_o      = mode_q;
endmodule

// File: rtl/lsp_mem_resp_chk.sv
`timescale 1ns/1ps
module lsp_mem_resp_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       busy,
   input logic       addr_ok,
   input logic       ld_vld,
   input logic       exc,
   input logic [1:0] exc_cause,
   input logic [2:0] mode,
   input logic       addr_vld
);
   p_resp_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({addr_ok, ld_vld, exc}));

   p_ack_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      addr_ok |-> busy);

   p_ack_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      addr_ok |=> !addr_ok);

   p_ld_after_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ld_vld |-> $past(addr_ok));

   p_ld_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ld_vld |=> (!busy && !ld_vld));

   p_exc_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
      exc |=> (!busy && !exc));

   p_exc_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      exc |-> (exc_cause != 2'd0));

   p_no_reaccept_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(busy) && !busy && $past(addr_vld) && addr_vld) |=> !busy);

   p_mode_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(mode));
endmodule

bind lsp_mem_resp lsp_mem_resp_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .busy     (busy_o),
   .addr_ok  (addr_ok_o),
   .ld_vld   (ld_vld_o),
   .exc      (exc_o),
   .exc_cause(exc_cause_o),
   .mode     (mode_o),
   .addr_vld (addr_vld_i)
);

// File: tb/lsp_mem_resp_test.sv
`timescale 1ns/1ps
module lsp_mem_resp_test;
   localparam int ADDR_W = 16;
   localparam int LANES  = 8;
   localparam int WORDS  = 16;
   localparam int DW     = 8 * LANES;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              ld_req_i, st_req_i, zero_blk_i, addr_vld_i;
   logic [ADDR_W-1:0] addr_i;
   logic [3:0]        len_i;
   logic              priv_i, virt_i, m32_i, st_vld_i;
   logic [DW-1:0]     st_data_i;
   logic              busy_o, addr_ok_o, ld_vld_o, exc_o;
   logic [DW-1:0]     ld_data_o;
   logic [1:0]        exc_cause_o;
   logic [2:0]        mode_o;

   int n_chk  = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   lsp_mem_resp #(.ADDR_W(ADDR_W), .LANES(LANES), .WORDS(WORDS)) uut (
      .clk(clk), .rst_n(rst_n), .ld_req_i(ld_req_i), .st_req_i(st_req_i),
      .zero_blk_i(zero_blk_i), .addr_vld_i(addr_vld_i), .addr_i(addr_i),
      .len_i(len_i), .priv_i(priv_i), .virt_i(virt_i), .m32_i(m32_i),
      .st_vld_i(st_vld_i), .st_data_i(st_data_i), .busy_o(busy_o),
      .addr_ok_o(addr_ok_o), .ld_vld_o(ld_vld_o), .ld_data_o(ld_data_o),
      .exc_o(exc_o), .exc_cause_o(exc_cause_o), .mode_o(mode_o)
   );

   typedef struct packed {
      logic        st;
      logic [15:0] addr;
      logic [3:0]  len;
      logic [63:0] data;
      logic [1:0]  exc;
      logic [63:0] exp;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 16'h0010, 4'd2, 64'h1234,               2'd0, 64'h0},
      '{1'b1, 16'h0012, 4'd2, 64'hABCD,               2'd0, 64'h0},
      '{1'b0, 16'h0010, 4'd4, 64'h0,                  2'd0, 64'hABCD1234},
      '{1'b0, 16'h0012, 4'd2, 64'h0,                  2'd0, 64'hABCD},
      '{1'b1, 16'h0018, 4'd8, 64'h0123456789ABCDEF,   2'd0, 64'h0},
      '{1'b0, 16'h0018, 4'd8, 64'h0,                  2'd0, 64'h0123456789ABCDEF},
      '{1'b0, 16'h001B, 4'd1, 64'h0,                  2'd0, 64'h89},
      '{1'b1, 16'h001C, 4'd4, 64'hFFFFFFFF11223344,   2'd0, 64'h0},
      '{1'b0, 16'h0018, 4'd8, 64'h0,                  2'd0, 64'h1122334489ABCDEF},
      '{1'b0, 16'h001E, 4'd4, 64'h0,                  2'd1, 64'h0},
      '{1'b1, 16'h0020, 4'd3, 64'hFF,                 2'd2, 64'h0},
      '{1'b1, 16'h001A, 4'd8, 64'hFFFFFFFFFFFFFFFF,   2'd1, 64'h0},
      '{1'b0, 16'h0018, 4'd8, 64'h0,                  2'd0, 64'h1122334489ABCDEF},
      '{1'b0, 16'h0011, 4'd2, 64'h0,                  2'd0, 64'hCD12}
   };

   task automatic check(input bit ok, input string tag,
                        input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic drop_req();
      ld_req_i = 1'b0; st_req_i = 1'b0; zero_blk_i = 1'b0; addr_vld_i = 1'b0;
   endtask

   task automatic access(input logic st, input logic both, input logic zero,
                         input logic [15:0] addr, input logic [3:0] len,
                         input logic [63:0] data, input logic [2:0] mode,
                         input int st_delay,
                         output logic [1:0] cause, output logic [63:0] rd);
      while (busy_o) @(negedge clk);
      ld_req_i = !st || both; st_req_i = st || both; zero_blk_i = zero;
      addr_i = addr; len_i = len; addr_vld_i = 1'b1;
      {priv_i, virt_i, m32_i} = mode;
      cause = 2'd0; rd = '0;
      @(negedge clk);
      check(busy_o, "R2 busy after acceptance", 64'(busy_o), 64'd1);
      check(mode_o == mode, "R11 captured mode", 64'(mode_o), 64'(mode));
      if (exc_o) begin
         cause = exc_cause_o;
         check(!addr_ok_o, "R7 no addr_ok with exception", 64'(addr_ok_o), 64'd0);
         @(negedge clk);
         check(!busy_o, "R7 busy drops after exception", 64'(busy_o), 64'd0);
         drop_req();
      end else begin
         check(addr_ok_o, "R3 addr_ok after acceptance", 64'(addr_ok_o), 64'd1);
         if (st || both) begin
            for (int d = 0; d < st_delay; d++) begin
               @(negedge clk);
               check(busy_o && !addr_ok_o, "R4 waiting for store data",
                     64'({busy_o, addr_ok_o}), 64'b10);
            end
            st_data_i = data; st_vld_i = 1'b1;
            @(negedge clk);
            st_vld_i = 1'b0; st_data_i = '1;
            check(!busy_o, "R4 busy drops after store strobe", 64'(busy_o), 64'd0);
            drop_req();
         end else begin
            @(negedge clk);
            check(ld_vld_o, "R5 load valid after addr_ok", 64'(ld_vld_o), 64'd1);
            rd = ld_data_o;
            drop_req();
            @(negedge clk);
            check(!busy_o && !ld_vld_o, "R5 single load pulse",
                  64'({busy_o, ld_vld_o}), 64'd0);
         end
      end
      @(negedge clk);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [1:0]  c;
      logic [63:0] r;
      rst_n = 1'b0; st_vld_i = 1'b0; st_data_i = '0; addr_i = '0; len_i = '0;
      priv_i = 1'b0; virt_i = 1'b0; m32_i = 1'b0;
      drop_req();
      repeat (3) @(negedge clk);
      check({busy_o, addr_ok_o, ld_vld_o, exc_o} == 4'b0, "R1 outputs in reset",
            64'({busy_o, addr_ok_o, ld_vld_o, exc_o}), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check({busy_o, addr_ok_o, ld_vld_o, exc_o} == 4'b0, "R1 outputs after reset",
            64'({busy_o, addr_ok_o, ld_vld_o, exc_o}), 64'd0);

      for (int i = 0; i < NV; i++) begin
         access(VECS[i].st, 1'b0, 1'b0, VECS[i].addr, VECS[i].len, VECS[i].data,
                3'(i), i % 3, c, r);
         check(c == VECS[i].exc, $sformatf("R7 cause vector %0d", i),
               64'(c), 64'(VECS[i].exc));
         if (!VECS[i].st && VECS[i].exc == 2'd0)
            check(r == VECS[i].exp, $sformatf("R6 load data vector %0d", i),
                  r, VECS[i].exp);
      end
      check(mode_o == 3'(NV - 1), "R11 mode held after end", 64'(mode_o), 64'(NV - 1));

      // R8: both selects
      access(1'b1, 1'b1, 1'b0, 16'h0010, 4'd2, 64'h0, 3'd5, 0, c, r);
      check(c == 2'd3, "R8 both selects cause", 64'(c), 64'd3);

      // R10: block zeroing ignores length, offset and data
      access(1'b1, 1'b0, 1'b1, 16'h001D, 4'd3, 64'hFFFF, 3'd1, 1, c, r);
      check(c == 2'd0, "R10 zeroing store accepted", 64'(c), 64'd0);
      access(1'b0, 1'b0, 1'b0, 16'h0018, 4'd8, 64'h0, 3'd2, 0, c, r);
      check(r == 64'h0, "R10 word cleared", r, 64'h0);
      access(1'b0, 1'b0, 1'b0, 16'h0010, 4'd4, 64'h0, 3'd3, 0, c, r);
      check(r == 64'hABCD1234, "R10 neighbour word kept", r, 64'hABCD1234);

      // R4: strobe while idle writes nothing
      st_data_i = 64'hDEADBEEFDEADBEEF; st_vld_i = 1'b1;
      @(negedge clk);
      st_vld_i = 1'b0;
      check(!busy_o, "R4 idle strobe leaves block idle", 64'(busy_o), 64'd0);
      access(1'b0, 1'b0, 1'b0, 16'h0018, 4'd8, 64'h0, 3'd4, 0, c, r);
      check(r == 64'h0, "R4 idle strobe ignored", r, 64'h0);

      // R12: address wraps modulo array size
      access(1'b1, 1'b0, 1'b0, 16'h0090, 4'd1, 64'h5A, 3'd6, 0, c, r);
      access(1'b0, 1'b0, 1'b0, 16'h0010, 4'd1, 64'h0, 3'd7, 0, c, r);
      check(r == 64'h5A, "R12 wrapped store visible", r, 64'h5A);
      access(1'b0, 1'b0, 1'b0, 16'h8011, 4'd1, 64'h0, 3'd0, 0, c, r);
      check(r == 64'h12, "R12 high bits ignored", r, 64'h12);

      // R9: held request not taken twice
      ld_req_i = 1'b1; st_req_i = 1'b0; addr_i = 16'h0010; len_i = 4'd2;
      addr_vld_i = 1'b1;
      @(negedge clk);
      check(addr_ok_o, "R9 first acceptance", 64'(addr_ok_o), 64'd1);
      @(negedge clk);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         check(!busy_o && !addr_ok_o, "R9 held request ignored",
               64'({busy_o, addr_ok_o}), 64'd0);
      end
      drop_req();
      @(negedge clk);
      access(1'b0, 1'b0, 1'b0, 16'h0010, 4'd2, 64'h0, 3'd2, 0, c, r);
      check(r == 64'h125A, "R9 new request after release", r, 64'h125A);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule